// File: doc/BRIEF.md
# Converter Serial Command Port

This block is the device-side serial port of a multi-channel sampling converter. A host drives a serial clock that idles high, an active-low frame select, and a data line into the device. The block reads a 16-bit word per frame, most significant bit first, with each data bit sampled on a falling clock edge. The top four bits of the word are an opcode and the low twelve bits are a configuration payload. On the return line the block sends the latest conversion result. After a configuration read it sends a mix of result bits and the configuration instead.

The block keeps three pieces of state: a 12-bit configuration register, the selected input channel and an awake flag. Opcodes that select a channel, wake the device or restore the default configuration take effect after four clock edges. Opcodes that read or write the configuration, or read data, need a full sixteen-edge frame. The analog converter is outside the block. A parallel result bus with a one-cycle strobe stands in for it. The serial pins are sampled in a single fast system clock domain that runs at least four times the serial clock rate.

Top module: `adcif_port`

## Requirements
- R1: After reset the configuration equals the `CFG_DEFAULT` parameter, the channel is 0 and the device is asleep (awake = 0). The data-out pin is 0 whenever frame select is high.
- R2: On a normal frame the data-out pin shows the held 16-bit result MSB first. Bit 15 appears when frame select falls, and bit 15-k appears after the k-th falling serial edge.
- R3: An opcode 0x0 to 0x7 (below `NUM_CH`) in the first four bits sets the channel to the opcode value and wakes the device. It takes effect at the fourth falling edge, so a four-edge frame is enough.
- R4: Opcode 0xE loads the low 12 bits of the word into the configuration, but only once the sixteenth falling edge is reached. A frame with this opcode that ends early leaves the configuration unchanged.
- R5: After a full frame with opcode 0xC, the next frame sends result bits 15..12 followed by the 12 configuration bits. The frame after that sends the plain result again.
- R6: Opcode 0xF loads `CFG_DEFAULT` into the configuration and wakes the device.
- R7: Opcode 0xB wakes the device and leaves the configuration and the channel unchanged.
- R8: Opcodes 0x8, 0x9 and 0xA change no state, whether the frame is short or full.
- R9: A pulse on `convDone` captures `convResult`. Only the next frame sends the captured value, and a pulse during a frame does not alter the word being shifted out.
- R10: A `convDone` pulse puts the device to sleep when configuration bit `NAP_BIT` is 1. When that bit is 0 the awake flag stays as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from host, idles high |
| csN | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| convDone | input | 1 | One-cycle strobe that a conversion finished |
| convResult | input | 16 | Conversion result captured on `convDone` |
| cfgOut | output | 12 | Configuration register |
| chanSel | output | 3 | Selected input channel |
| awake | output | 1 | Device awake flag |

## Verification
The port is driven with four-edge frames, full frames and frames cut off early. A cut-off write frame shows whether the configuration commit waits for the sixteenth edge or fires at the fourth. Read-configuration frames are followed by two plain frames, which shows that the mixed word is sent exactly once, in the frame after the request. Reserved opcodes are sent in both frame lengths, and a result strobe arrives in the middle of a frame. These cases separate state that must hold from state that may change.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  localparam int FRAME_BITS = 16;
  localparam int OP_W = 4;
  localparam int CFG_W = FRAME_BITS - OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_WAKE      = 4'hB,
    OP_READ_CFG  = 4'hC,
    OP_READ_DATA = 4'hD,
    OP_WRITE_CFG = 4'hE,
    OP_DEFAULT   = 4'hF
  } op_e;

  typedef struct packed {
    logic             frameStart;
    logic             sample;
    logic             sdiBit;
    logic             setChan;
    logic             wake;
    logic             loadDef;
    logic             writeCfg;
    logic             armRead;
    logic [CFG_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/adcif_sync.sv
module adcif_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/adcif_ctrl.sv
module adcif_ctrl
  import adcif_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclkIn,
  input  logic                  csN,
  input  logic                  sdi,
  input  logic [FRAME_BITS-2:0] rxWord,
  output strobe_t               stb,
  output logic [CH_W-1:0]       chanVal,
  output logic                  csActive
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic sclkSync, csSync, sdiSync;
  logic sclkPrev, csPrev;
  logic [CNT_W-1:0] edgeCnt;
  logic sclkFall, csFall, sampleNow, shortDone, fullDone;
  logic [FRAME_BITS-1:0] newWord;
  logic [OP_W-1:0] opShort, opFull;

  adcif_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclk (
    .clk(clk), .rstN(rstN), .din(sclkIn), .dout(sclkSync));
  adcif_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs (
    .clk(clk), .rstN(rstN), .din(csN), .dout(csSync));
  adcif_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sdi (
    .clk(clk), .rstN(rstN), .din(sdi), .dout(sdiSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkSync;
      csPrev   <= csSync;
    end
  end

  assign csActive  = ~csSync;
  assign csFall    = csPrev & ~csSync;
  assign sclkFall  = sclkPrev & ~sclkSync;
  assign sampleNow = sclkFall && csActive && (edgeCnt < CNT_W'(FRAME_BITS));
  assign newWord   = {rxWord, sdiSync};
  assign shortDone = sampleNow && (edgeCnt == CNT_W'(OP_W - 1));
  assign fullDone  = sampleNow && (edgeCnt == CNT_W'(FRAME_BITS - 1));
  assign opShort   = newWord[OP_W-1:0];
  assign opFull    = newWord[FRAME_BITS-1 -: OP_W];
  assign chanVal   = opShort[CH_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   edgeCnt <= '0;
    else if (!csActive || csFall) edgeCnt <= '0;
    else if (sampleNow)          edgeCnt <= edgeCnt + 1'b1;
  end

  always_comb begin
    stb            = '0;
    stb.frameStart = csFall;
    stb.sample     = sampleNow;
    stb.sdiBit     = sdiSync;
    stb.data       = newWord[CFG_W-1:0];
    if (shortDone) begin
      if (opShort < OP_W'(NUM_CH)) begin
        stb.setChan = 1'b1;
        stb.wake    = 1'b1;
      end else if (opShort == OP_WAKE) begin
        stb.wake = 1'b1;
      end else if (opShort == OP_DEFAULT) begin
        stb.loadDef = 1'b1;
        stb.wake    = 1'b1;
      end
    end
    if (fullDone) begin
      if (opFull == OP_WRITE_CFG)     stb.writeCfg = 1'b1;
      else if (opFull == OP_READ_CFG) stb.armRead  = 1'b1;
    end
  end
endmodule

// File: rtl/adcif_dp.sv
module adcif_dp
  import adcif_pkg::*;
#(
  parameter int               NUM_CH      = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 12'h6F4,
  parameter int               NAP_BIT     = 2,
  localparam int              CH_W        = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [CH_W-1:0]       chanVal,
  input  logic                  csActive,
  input  logic                  convDone,
  input  logic [FRAME_BITS-1:0] convResult,
  output logic [FRAME_BITS-2:0] rxWord,
  output logic                  sdo,
  output logic [CFG_W-1:0]      cfgOut,
  output logic [CH_W-1:0]       chanSel,
  output logic                  awake
);
  logic [FRAME_BITS-1:0] resultHold;
  logic [FRAME_BITS-1:0] outShift;
  logic                  readPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         resultHold <= '0;
    else if (convDone) resultHold <= convResult;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outShift <= '0;
      readPend <= 1'b0;
    end else if (stb.frameStart) begin
      outShift <= readPend ? {resultHold[FRAME_BITS-1 -: OP_W], cfgOut} : resultHold;
      readPend <= 1'b0;
    end else begin
      if (stb.sample)  outShift <= {outShift[FRAME_BITS-2:0], 1'b0};
      if (stb.armRead) readPend <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxWord <= '0;
    else if (stb.sample) rxWord <= {rxWord[FRAME_BITS-3:0], stb.sdiBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgOut <= CFG_DEFAULT;
    else if (stb.writeCfg) cfgOut <= stb.data;
    else if (stb.loadDef)  cfgOut <= CFG_DEFAULT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            chanSel <= '0;
    else if (stb.setChan) chanSel <= chanVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            awake <= 1'b0;
    else if (stb.wake)                    awake <= 1'b1;
    else if (convDone && cfgOut[NAP_BIT]) awake <= 1'b0;
  end

  assign sdo = csActive & outShift[FRAME_BITS-1];
endmodule

// File: rtl/adcif_port.sv
module adcif_port
  import adcif_pkg::*;
#(
  parameter int               NUM_CH      = 8,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = 12'h6F4,
  parameter int               NAP_BIT     = 2,
  parameter int               SYNC_STAGES = 2,
  localparam int              CH_W        = $clog2(NUM_CH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclkIn,
  input  logic                  csN,
  input  logic                  sdi,
  output logic                  sdo,
  input  logic                  convDone,
  input  logic [FRAME_BITS-1:0] convResult,
  output logic [CFG_W-1:0]      cfgOut,
  output logic [CH_W-1:0]       chanSel,
  output logic                  awake
);
  strobe_t               stb;
  logic [CH_W-1:0]       chanVal;
  logic                  csActive;
  logic [FRAME_BITS-2:0] rxWord;

  adcif_ctrl #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csN(csN), .sdi(sdi),
    .rxWord(rxWord), .stb(stb), .chanVal(chanVal), .csActive(csActive));

  adcif_dp #(.NUM_CH(NUM_CH), .CFG_DEFAULT(CFG_DEFAULT), .NAP_BIT(NAP_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .chanVal(chanVal), .csActive(csActive),
    .convDone(convDone), .convResult(convResult), .rxWord(rxWord), .sdo(sdo),
    .cfgOut(cfgOut), .chanSel(chanSel), .awake(awake));
endmodule

// File: rtl/adcif_port_chk.sv
module adcif_port_chk #(
  parameter int CFG_W   = 12,
  parameter int CH_W    = 3,
  parameter int NAP_BIT = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             sdo,
  input logic             convDone,
  input logic [CFG_W-1:0] cfgOut,
  input logic [CH_W-1:0]  chanSel,
  input logic             awake,
  input logic             setChan,
  input logic             wake,
  input logic             loadDef,
  input logic             writeCfg,
  input logic             armRead
);
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !sdo); // R1

  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(setChan) |-> $stable(chanSel)); // R3

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !($past(writeCfg) || $past(loadDef)) |-> $stable(cfgOut)); // R4

  AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rstN)
    $past(wake) |-> awake); // R7

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setChan, loadDef, writeCfg, armRead})); // R8

  AST_NAP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $past(convDone && cfgOut[NAP_BIT] && !wake) |-> !awake); // R10
endmodule

bind adcif_port adcif_port_chk #(.CFG_W(CFG_W), .CH_W(CH_W), .NAP_BIT(NAP_BIT)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sdo(sdo), .convDone(convDone),
  .cfgOut(cfgOut), .chanSel(chanSel), .awake(awake),
  .setChan(stb.setChan), .wake(stb.wake), .loadDef(stb.loadDef),
  .writeCfg(stb.writeCfg), .armRead(stb.armRead));

// File: tb/sim_adcif_port.sv
module sim_adcif_port;
  localparam logic [11:0] DEF = 12'h6F4;
  localparam int HALF = 8;

  typedef struct {
    logic [15:0] val;
    int          nBits;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b1;
  logic csN = 1'b1;
  logic sdi = 1'b0;
  logic convDone = 1'b0;
  logic [15:0] convResult = '0;
  logic sdo;
  logic [11:0] cfgOut;
  logic [2:0] chanSel;
  logic awake;

  int nRun = 0;
  int nFail = 0;
  item_t expQ[$];
  item_t gotQ[$];

  always #5 clk = ~clk;

  adcif_port #(.CFG_DEFAULT(DEF)) u0 (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csN(csN), .sdi(sdi), .sdo(sdo),
    .convDone(convDone), .convResult(convResult), .cfgOut(cfgOut),
    .chanSel(chanSel), .awake(awake));

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseResult(input logic [15:0] v);
    @(negedge clk);
    convResult = v;
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    waitClk(4);
  endtask

  task automatic frame(input logic [15:0] word, input int n, input logic [15:0] expSdo,
                       input string tag, input logic mid, input logic [15:0] midVal);
    item_t e;
    item_t g;
    logic [15:0] cap;
    e.val = expSdo; e.nBits = n; e.tag = tag;
    expQ.push_back(e);
    cap = '0;
    @(negedge clk);
    csN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = word[15-i];
      waitClk(HALF);
      cap[15-i] = sdo;
      sclkIn = 1'b0;
      waitClk(HALF);
      sclkIn = 1'b1;
      if (mid && i == 7) begin
        convResult = midVal;
        convDone = 1'b1;
        @(negedge clk);
        convDone = 1'b0;
      end
    end
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
    g.val = cap; g.nBits = n; g.tag = tag;
    gotQ.push_back(g);
  endtask

  // Monitor: pairs each captured frame with the word the driver expected.
  initial begin
    forever begin
      item_t e;
      item_t g;
      logic [15:0] mask;
      wait (gotQ.size() > 0);
      g = gotQ.pop_front();
      e = expQ.pop_front();
      mask = 16'hFFFF << (16 - e.nBits);
      check({e.tag, " sdo word"}, g.val & mask, e.val & mask);
    end
  end

  initial begin
    waitClk(150000);
    nRun++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    waitClk(3);
    check("R1 sdo idle in reset", {15'd0, sdo}, 16'd0);
    rstN = 1'b1;
    waitClk(3);
    check("R1 cfg reset", {4'd0, cfgOut}, {4'd0, DEF});
    check("R1 chan reset", {13'd0, chanSel}, 16'd0);
    check("R1 asleep", {15'd0, awake}, 16'd0);

    pulseResult(16'hA5C3);
    frame(16'hD000, 16, 16'hA5C3, "R2 R9 read data", 1'b0, '0);
    check("R1 sdo idle after frame", {15'd0, sdo}, 16'd0);

    frame(16'h5000, 4, 16'hA5C3, "R3 select ch5", 1'b0, '0);
    check("R3 chan", {13'd0, chanSel}, 16'd5);
    check("R3 awake", {15'd0, awake}, 16'd1);

    frame(16'hE123, 16, 16'hA5C3, "R4 write cfg", 1'b0, '0);
    check("R4 cfg written", {4'd0, cfgOut}, 16'h0123);
    frame(16'hE7FF, 10, 16'hA5C3, "R4 short write", 1'b0, '0);
    check("R4 short write discarded", {4'd0, cfgOut}, 16'h0123);

    frame(16'h9ABC, 16, 16'hA5C3, "R8 reserved full", 1'b0, '0);
    frame(16'h8000, 4, 16'hA5C3, "R8 reserved short 8", 1'b0, '0);
    frame(16'hA000, 4, 16'hA5C3, "R8 reserved short A", 1'b0, '0);
    check("R8 chan kept", {13'd0, chanSel}, 16'd5);
    check("R8 cfg kept", {4'd0, cfgOut}, 16'h0123);
    check("R8 awake kept", {15'd0, awake}, 16'd1);

    pulseResult(16'h3C01);
    check("R10 nap bit clear keeps awake", {15'd0, awake}, 16'd1);

    frame(16'hC000, 16, 16'h3C01, "R5 read cfg request", 1'b0, '0);
    frame(16'hD000, 16, 16'h3123, "R5 mixed readback", 1'b0, '0);
    frame(16'hD000, 16, 16'h3C01, "R5 back to result", 1'b0, '0);

    frame(16'hF000, 4, 16'h3C01, "R6 load default", 1'b0, '0);
    check("R6 cfg default", {4'd0, cfgOut}, {4'd0, DEF});
    check("R6 awake", {15'd0, awake}, 16'd1);

    pulseResult(16'h1111);
    check("R10 nap bit set sleeps", {15'd0, awake}, 16'd0);

    frame(16'hB000, 4, 16'h1111, "R7 wake", 1'b0, '0);
    check("R7 awake", {15'd0, awake}, 16'd1);
    check("R7 chan kept", {13'd0, chanSel}, 16'd5);
    check("R7 cfg kept", {4'd0, cfgOut}, {4'd0, DEF});

    frame(16'hD000, 16, 16'h1111, "R9 strobe mid frame", 1'b1, 16'h2222);
    frame(16'h7000, 16, 16'h2222, "R9 next frame new result", 1'b0, '0);
    check("R3 chan 7", {13'd0, chanSel}, 16'd7);
    frame(16'h0000, 4, 16'h2222, "R3 select ch0", 1'b0, '0);
    check("R3 chan 0", {13'd0, chanSel}, 16'd0);

    wait (gotQ.size() == 0);
    waitClk(4);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule